// File: doc/BRIEF.md
# CRT Sync Skew Aligner

This block sits at the end of a video output path and lines the horizontal and vertical sync pulses up with the pixel stream. Pixel data and its blanking flag travel through a fixed pipeline of four pixel clocks. The two syncs travel through a tapped delay line whose length, from zero to seven clocks, is picked by a 3-bit skew code. Because the baseline code (`100`) gives the syncs the same four-clock delay as the pixels, the syncs can be placed up to four clocks ahead of the pixel data or up to three clocks behind it. This lets the sync timing absorb latency added elsewhere in the video path.

The raw syncs arrive active-high. After the delay line, each sync is given its own output polarity. Polarity is applied after the delay, so the skew code and the polarity bits do not affect each other. The delay line keeps all seven stages filled at all times, so a new skew code selects a different tap on the same clock. On reset every stage is cleared to the inactive sync level and the pixel pipeline is cleared to blanked black.

Top module: `crt_sync_skew`

## Requirements
- R1: `pix_o` and `blank_o` repeat `pix_i` and `blank_i` exactly four clocks later.
- R2: For skew code N (0 to 7), each sync output follows its raw input delayed by N clocks. Code 0 is a combinational pass-through. Both syncs use the same code.
- R3: Code `100` is the baseline: a sync pulse presented together with a pixel leaves in the same cycle as that pixel.
- R4: Codes `000`, `001`, `010` and `011` make the sync leave 4, 3, 2 and 1 clocks before the pixel it was presented with.
- R5: Codes `101`, `110` and `111` make the sync leave 1, 2 and 3 clocks after the pixel it was presented with.
- R6: With `vsync_pol` at 0, `vsync_o` idles low and is high while the delayed sync is active. With `vsync_pol` at 1, it idles high and is low while the delayed sync is active.
- R7: `hsync_pol` controls `hsync_o` in the same way that `vsync_pol` controls `vsync_o`.
- R8: Changing a polarity bit inverts that output in the same cycle and leaves the skew timing unchanged. Changing the skew code leaves the levels unchanged.
- R9: A new skew code takes effect in the first cycle it is applied. The output then shows the history delayed by the new amount, which is always within the 8-clock settling bound.
- R10: While `rst` is high, and after it is released, the delay stages hold the inactive level. With code N, no stale pulse appears during the first N cycles after reset. During reset, with raw syncs idle, each sync output sits at its polarity's idle level, `pix_o` is 0 and `blank_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_i | input | DATA_W (24) | Incoming pixel data |
| blank_i | input | 1 | Incoming blanking flag |
| hsync_i | input | 1 | Raw horizontal sync, active high |
| vsync_i | input | 1 | Raw vertical sync, active high |
| skew_code | input | CODE_W (3) | Sync delay in clocks; `100` is the baseline |
| hsync_pol | input | 1 | 1 = horizontal sync output active low |
| vsync_pol | input | 1 | 1 = vertical sync output active low |
| pix_o | output | DATA_W (24) | Pixel data after the fixed delay |
| blank_o | output | 1 | Blanking flag after the fixed delay |
| hsync_o | output | 1 | Skewed horizontal sync at its programmed polarity |
| vsync_o | output | 1 | Skewed vertical sync at its programmed polarity |

## Verification
Embedded properties check on every cycle that each stage of the pixel pipeline and of the sync delay line takes the previous stage's value. They also check that every stage reads as cleared on the first cycle after reset, and that a polarity flip with a steady delayed sync inverts the output at once. The relative skew for each code, the codes that move the sync earlier versus later, the effect of changing the code in mid-stream, and the absence of stale pulses after a mid-run reset can only be seen in the bench's scenarios. There, a history model predicts every output cycle and a pulse-timing sweep measures the skew between a marked pixel and its sync edge.

// File: rtl/crt_skew_pkg.sv
package crt_skew_pkg;

    // Internal active-high sync pair carried through the delay line.
    typedef struct packed {
        logic hs;
        logic vs;
    } sync_pair_t;

    localparam sync_pair_t SYNC_IDLE = '{hs: 1'b0, vs: 1'b0};

endpackage

// File: rtl/crt_pix_pipe.sv
module crt_pix_pipe #(
    parameter int W     = 24,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pix_i,
    input  logic         blank_i,
    output logic [W-1:0] pix_o,
    output logic         blank_o
);
    localparam int LW = W + 1;
    localparam logic [LW-1:0] RST_WORD = {1'b1, {W{1'b0}}};

    logic [LW-1:0] stg [1:DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i <= DEPTH; i++) stg[i] <= RST_WORD;
        end else begin
            stg[1] <= {blank_i, pix_i};
            for (int i = 2; i <= DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign {blank_o, pix_o} = stg[DEPTH];

    // R1: the first stage captures the word presented one clock earlier
    p_pipe_entry_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stg[1] == $past({blank_i, pix_i}));

    generate
        for (genvar g = 2; g <= DEPTH; g++) begin : g_chk
            // R1: each stage hands its word on after exactly one clock
            p_pipe_shift_r1: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> stg[g] == $past(stg[g-1]));
        end
        for (genvar g = 1; g <= DEPTH; g++) begin : g_rst
            // R10: a released reset leaves every stage blanked black
            p_pipe_rst_r10: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> stg[g] == RST_WORD);
        end
    endgenerate

endmodule

// File: rtl/crt_sync_tapline.sv
module crt_sync_tapline
    import crt_skew_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  sync_pair_t        din,
    input  logic [CODE_W-1:0] code,
    output sync_pair_t        dout
);
    localparam int TAPS = (1 << CODE_W) - 1;

    sync_pair_t stg [1:TAPS];
    sync_pair_t tap [0:TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i <= TAPS; i++) stg[i] <= SYNC_IDLE;
        end else begin
            stg[1] <= din;
            for (int i = 2; i <= TAPS; i++) stg[i] <= stg[i-1];
        end
    end

    assign tap[0] = din;
    generate
        for (genvar g = 1; g <= TAPS; g++) begin : g_tap
            assign tap[g] = stg[g];
        end
    endgenerate

    assign dout = tap[code];

    // R2: the delay line advances one stage per clock regardless of the code
    p_tap_entry_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stg[1] == $past(din));

    generate
        for (genvar g = 2; g <= TAPS; g++) begin : g_chk
            p_tap_shift_r2: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> stg[g] == $past(stg[g-1]));
        end
        for (genvar g = 1; g <= TAPS; g++) begin : g_rst
            // R10: no stale sync survives a reset
            p_tap_rst_r10: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> stg[g] == SYNC_IDLE);
        end
    endgenerate

endmodule

// File: rtl/crt_sync_polarity.sv
module crt_sync_polarity
    import crt_skew_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sync_pair_t act,
    input  logic       hpol,
    input  logic       vpol,
    output logic       hs_o,
    output logic       vs_o
);
    always_comb begin
        hs_o = act.hs ^ hpol;
        vs_o = act.vs ^ vpol;
    end

    // R7/R8: flipping the horizontal polarity with a steady delayed sync inverts the pin
    p_hpol_flip_r7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(hpol) && $stable(act.hs)) |-> hs_o != $past(hs_o));

    // R6/R8: same for the vertical polarity
    p_vpol_flip_r6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(vpol) && $stable(act.vs)) |-> vs_o != $past(vs_o));

    // R8: with polarity steady and the delayed sync steady, the pin does not move
    p_level_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ($stable(hpol) && $stable(act.hs) && $stable(vpol) && $stable(act.vs))
        |-> ($stable(hs_o) && $stable(vs_o)));

endmodule

// File: rtl/crt_sync_skew.sv
module crt_sync_skew
    import crt_skew_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pix_i,
    input  logic              blank_i,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic [CODE_W-1:0] skew_code,
    input  logic              hsync_pol,
    input  logic              vsync_pol,
    output logic [DATA_W-1:0] pix_o,
    output logic              blank_o,
    output logic              hsync_o,
    output logic              vsync_o
);
    // Baseline code sits at the middle of the code range.
    localparam int PIPE_DLY = 1 << (CODE_W - 1);

    sync_pair_t raw_sync;
    sync_pair_t dly_sync;

    assign raw_sync = '{hs: hsync_i, vs: vsync_i};

    crt_pix_pipe #(
        .W     (DATA_W),
        .DEPTH (PIPE_DLY)
    ) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .pix_i   (pix_i),
        .blank_i (blank_i),
        .pix_o   (pix_o),
        .blank_o (blank_o)
    );

    crt_sync_tapline #(
        .CODE_W (CODE_W)
    ) u_taps (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_sync),
        .code (skew_code),
        .dout (dly_sync)
    );

    crt_sync_polarity u_pol (
        .clk  (clk),
        .rst  (rst),
        .act  (dly_sync),
        .hpol (hsync_pol),
        .vpol (vsync_pol),
        .hs_o (hsync_o),
        .vs_o (vsync_o)
    );

endmodule

// File: tb/crt_sync_skew_tb.sv
module crt_sync_skew_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 24;
    localparam int HN = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] pix_i = '0;
    logic          blank_i = 1'b1;
    logic          hsync_i = 1'b0;
    logic          vsync_i = 1'b0;
    logic [2:0]    skew_code = 3'b100;
    logic          hsync_pol = 1'b0;
    logic          vsync_pol = 1'b0;
    logic [DW-1:0] pix_o;
    logic          blank_o;
    logic          hsync_o;
    logic          vsync_o;

    int n_chk = 0;
    int n_fail = 0;
    int step_no = 0;
    bit finished = 0;

    // History of applied inputs; index 0 is the value driven this cycle.
    logic          hh [0:HN-1];
    logic          hv [0:HN-1];
    logic          hb [0:HN-1];
    logic [DW-1:0] hp [0:HN-1];

    logic [2:0] prev_code = 3'b100;
    logic       prev_hpol = 1'b0;
    logic       prev_vpol = 1'b0;

    crt_sync_skew u_dut (
        .clk       (clk),
        .rst       (rst),
        .pix_i     (pix_i),
        .blank_i   (blank_i),
        .hsync_i   (hsync_i),
        .vsync_i   (vsync_i),
        .skew_code (skew_code),
        .hsync_pol (hsync_pol),
        .vsync_pol (vsync_pol),
        .pix_o     (pix_o),
        .blank_o   (blank_o),
        .hsync_o   (hsync_o),
        .vsync_o   (vsync_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Relative skew of the sync against the pixel it was presented with.
    function automatic int skew_of(input logic [2:0] c);
        case (c)
            3'b000: return -4;
            3'b001: return -3;
            3'b010: return -2;
            3'b011: return -1;
            3'b100: return 0;
            3'b101: return 1;
            3'b110: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic string region_tag(input logic [2:0] c);
        if (c == 3'b100) return "R3";
        else if (c < 3'b100) return "R4";
        else return "R5";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s step=%0d actual=%0h expected=%0h", tag, step_no, act, exp);
        end
    endtask

    task automatic fill_reset_history();
        for (int i = 0; i < HN; i++) begin
            hh[i] = 1'b0;
            hv[i] = 1'b0;
            hb[i] = 1'b1;
            hp[i] = '0;
        end
    endtask

    task automatic do_reset(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            rst = 1'b1;
            hsync_i = 1'b0;
            vsync_i = 1'b0;
            pix_i = $urandom;
            blank_i = $urandom;
            #1;
            if (k > 0) begin
                chk("R10 reset pix_o", pix_o, '0);
                chk("R10 reset blank_o", blank_o, 1'b1);
                chk("R10 reset hsync_o idle", hsync_o, hsync_pol);
                chk("R10 reset vsync_o idle", vsync_o, vsync_pol);
            end
        end
        fill_reset_history();
    endtask

    // One pixel clock: drive at the falling edge, then compare with the model.
    task automatic step(input logic hs, input logic vs, input logic bl,
                        input logic [DW-1:0] px, input logic [2:0] code,
                        input logic hpol, input logic vpol);
        string ctag;
        int    d;
        @(negedge clk);
        rst = 1'b0;
        for (int i = HN-1; i > 0; i--) begin
            hh[i] = hh[i-1];
            hv[i] = hv[i-1];
            hb[i] = hb[i-1];
            hp[i] = hp[i-1];
        end
        hh[0] = hs; hv[0] = vs; hb[0] = bl; hp[0] = px;
        hsync_i = hs; vsync_i = vs; blank_i = bl; pix_i = px;
        skew_code = code; hsync_pol = hpol; vsync_pol = vpol;
        step_no++;
        #1;
        d = int'(code);
        ctag = $sformatf("R2 %s code=%0d", region_tag(code), d);
        if (code != prev_code) ctag = {ctag, " R9"};
        if (hpol != prev_hpol || vpol != prev_vpol) ctag = {ctag, " R8"};
        chk("R1 pix_o", pix_o, hp[4]);
        chk("R1 blank_o", blank_o, hb[4]);
        chk({ctag, " R7 hsync_o"}, hsync_o, hh[d] ^ hpol);
        chk({ctag, " R6 vsync_o"}, vsync_o, hv[d] ^ vpol);
        prev_code = code; prev_hpol = hpol; prev_vpol = vpol;
    endtask

    initial begin
        void'($urandom(32'd90210));
        fill_reset_history();

        // Reset state.
        do_reset(4);

        // Directed sweep: one marked pixel with a one-cycle sync pulse per code.
        for (int c = 0; c < 8; c++) begin
            int pix_at;
            int hs_at;
            int vs_at;
            logic [DW-1:0] mark;
            logic hp_sel;
            logic vp_sel;
            pix_at = -1; hs_at = -1; vs_at = -1;
            mark = 24'hA5_0000 | DW'(c);
            hp_sel = c[0];
            vp_sel = c[1];
            for (int k = 0; k < 10; k++)
                step(1'b0, 1'b0, 1'b0, DW'(k), 3'(c), hp_sel, vp_sel);
            for (int k = 0; k < 12; k++) begin
                if (k == 0) step(1'b1, 1'b1, 1'b0, mark, 3'(c), hp_sel, vp_sel);
                else        step(1'b0, 1'b0, 1'b0, DW'(k), 3'(c), hp_sel, vp_sel);
                if (pix_o == mark && pix_at < 0) pix_at = step_no;
                if ((hsync_o ^ hp_sel) && hs_at < 0) hs_at = step_no;
                if ((vsync_o ^ vp_sel) && vs_at < 0) vs_at = step_no;
            end
            chk($sformatf("%s skew hsync code=%0d", region_tag(3'(c)), c),
                32'(hs_at - pix_at), 32'(skew_of(3'(c))));
            chk($sformatf("%s skew vsync code=%0d", region_tag(3'(c)), c),
                32'(vs_at - pix_at), 32'(skew_of(3'(c))));
        end

        // Polarity flips alone on a long sync pulse, fixed code.
        for (int k = 0; k < 24; k++)
            step(k >= 4 && k < 16, k >= 6 && k < 18, 1'b1, DW'($urandom),
                 3'b110, logic'(k % 3 == 0), logic'(k % 5 == 0));

        // Constrained random stream with occasional code and polarity changes.
        begin
            logic [2:0] rc;
            logic rhp;
            logic rvp;
            rc = 3'b100; rhp = 1'b0; rvp = 1'b1;
            for (int k = 0; k < 800; k++) begin
                if ($urandom_range(0, 15) == 0) rc = 3'($urandom);
                if ($urandom_range(0, 19) == 0) rhp = ~rhp;
                if ($urandom_range(0, 23) == 0) rvp = ~rvp;
                step(logic'($urandom_range(0, 3) == 0), logic'($urandom_range(0, 5) == 0),
                     logic'($urandom), DW'($urandom), rc, rhp, rvp);
            end
        end

        // Mid-run reset with the longest delay: no stale pulses may leak out.
        for (int k = 0; k < 8; k++)
            step(1'b1, 1'b1, 1'b0, DW'($urandom), 3'b111, 1'b0, 1'b0);
        do_reset(3);
        for (int k = 0; k < 10; k++) begin
            step(1'b1, 1'b1, 1'b0, DW'(k + 1), 3'b111, 1'b1, 1'b0);
            if (k < 7) begin
                chk("R10 no stale hsync after reset", hsync_o, 1'b1);
                chk("R10 no stale vsync after reset", vsync_o, 1'b0);
            end
        end

        // Code 0 bypass corner: same-cycle pass-through.
        step(1'b1, 1'b0, 1'b0, '1, 3'b000, 1'b0, 1'b0);
        chk("R2 code 0 pass-through hsync", hsync_o, 1'b1);
        step(1'b0, 1'b1, 1'b0, '0, 3'b000, 1'b0, 1'b1);
        chk("R2 code 0 pass-through vsync", vsync_o, 1'b0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at step=%0d", step_no);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule